// File: doc/BRIEF.md
# Interval Timer with Square-Wave Output

This block is one down-counting timer channel. It runs from a single system clock, and its count rate comes from one of several count-clock enables. After a start trigger, the first selected enable pulse loads the counter from a 16-bit period register. Each later enable pulse decrements the counter. On the enable pulse that finds the counter at zero, the block does three things:

- it emits a one-cycle interrupt pulse;
- it inverts the square-wave output;
- it reloads the counter from the period register.

The interrupt therefore repeats every (period + 1) count clocks, and the output is a 50% duty square wave of twice that period.

A mode input chooses whether the start load itself also produces an interrupt and a toggle. The period register can be rewritten at any time, and the new value is picked up at the next reload. The count-clock select is sampled only while the channel is stopped. A stop request freezes the counter and the output level. The next start begins again with a fresh load.

Top module: `itv_timer`

## Requirements
- R1: While reset is asserted, irq_o, tout_o and count_o are all 0.
- R2: A count tick is a cycle in which the channel runs and the selected enable is high. On each tick that is not a load, count_o decreases by exactly 1.
- R3: The first tick after a start pulse loads count_o from the period register. With irq_at_start_i = 1 that tick also pulses irq_o and toggles tout_o. With irq_at_start_i = 0 it does neither.
- R4: A tick while count_o is 0 reloads the counter and sets irq_o to 1 for exactly one clock cycle, the cycle after that tick's edge. irq_o is never high otherwise.
- R5: tout_o changes level exactly in the cycles where irq_o is high. It therefore forms a 50% duty square wave with a period of 2 × (P + 1) ticks.
- R6: With period value P and a steady tick stream, successive interrupts are (P + 1) ticks apart.
- R7: A period write while the counter runs does not alter the period in progress. The new value governs the next period.
- R8: After a stop request, count_o and tout_o hold their values until the next start. If stop and start arrive in the same cycle, stop wins.
- R9: csel_i encoding: 0 to 3 select pre_en_i[0] to pre_en_i[3], 4 selects the slow enable divided by 4, and 5 to 7 select no ticks. csel_i is captured only while the channel is stopped, so changes made while it runs have no effect.
- R10: With select 4, a tick occurs on every fourth slow_en_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop request pulse |
| csel_i | input | 3 | Count-clock select |
| pre_en_i | input | 4 | Prescaled count-clock enables |
| slow_en_i | input | 1 | Slow-clock enable, divided by 4 internally |
| period_i | input | 16 | Period value to write |
| period_we_i | input | 1 | Period register write strobe |
| irq_at_start_i | input | 1 | Fire interrupt and toggle on the start load |
| irq_o | output | 1 | Interrupt pulse |
| tout_o | output | 1 | Square-wave output |
| count_o | output | 16 | Current counter value |

## Verification
A wrong counter value shows up on count_o in the same cycle. It then shifts every later interrupt, so the error repeats period after period. A stale pending-load flag or a wrongly latched select shows up as an interrupt that is missing, extra, or early, within one count-clock period of the start. A missed toggle inverts tout_o for the rest of the run. Comparing the outputs against a reference on every clock therefore catches these faults within at most one period.

// File: rtl/itv_timer.sv
module itv_timer #(
  parameter int CW   = 16,
  parameter int NPRE = 4,
  parameter int SW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [SW-1:0] csel_i,
  input  logic [NPRE-1:0] pre_en_i,
  input  logic          slow_en_i,
  input  logic [CW-1:0] period_i,
  input  logic          period_we_i,
  input  logic          irq_at_start_i,
  output logic          irq_o,
  output logic          tout_o,
  output logic [CW-1:0] count_o
);
  localparam logic [SW-1:0] SLOW_SEL = SW'(NPRE);

  logic [CW-1:0] prd_q, cnt_q;
  logic [SW-1:0] sel_q;
  logic [1:0]    div_q;
  logic run_q, pend_q, irq_q, tog_q;
  logic sel_en, tick, at_zero, reload, fire;

  wire slow_tick = slow_en_i && (div_q == 2'd3);

  always_comb begin
    sel_en = 1'b0;
    for (int k = 0; k < NPRE; k++)
      if (sel_q == SW'(k)) sel_en = pre_en_i[k];
    if (sel_q == SLOW_SEL) sel_en = slow_tick;
  end

  assign tick    = run_q && sel_en;
  assign at_zero = (cnt_q == '0);
  assign reload  = tick && (pend_q || at_zero);
  assign fire    = tick && (pend_q ? irq_at_start_i : at_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q  <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (slow_en_i) div_q <= div_q + 2'd1;
      if (period_we_i) prd_q <= period_i;
      if (!run_q) sel_q <= csel_i;
      if (reload) cnt_q <= prd_q;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      irq_q <= fire;
      if (fire) tog_q <= ~tog_q;
      if (stop_i) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (start_i) begin
        run_q  <= 1'b1;
        pend_q <= 1'b1;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign irq_o   = irq_q;
  assign tout_o  = tog_q;
  assign count_o = cnt_q;
endmodule

module itv_timer_chk #(
  parameter int CW = 16,
  parameter int SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          tout_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] prd_q,
  input logic [SW-1:0] sel_q,
  input logic          run_q
);
  AST_TOGGLE_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_o != $past(tout_o)) == irq_o); // R5

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      (count_o == $past(count_o) - 1'b1) || (count_o == $past(prd_q))); // R2

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(run_q)); // R4

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(count_o) && $stable(tout_o)); // R8

  AST_SELECT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable(sel_q)); // R9
endmodule

bind itv_timer itv_timer_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .tout_o(tout_o),
  .count_o(count_o), .prd_q(prd_q), .sel_q(sel_q), .run_q(run_q));

// File: tb/tb_itv_timer.sv
`timescale 1ns/1ps
module tb_itv_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, we = 1'b0, mode = 1'b0, slow_en = 1'b0;
  logic [2:0] csel = 3'd0;
  logic [3:0] pre_en = 4'd0;
  logic [15:0] period = 16'd0;
  logic irq, tout;
  logic [15:0] count;

  int n_chk = 0, n_fail = 0, cyc = 0, ncyc = 0;
  int m_cnt, m_prd, m_sel, m_div, m_run, m_pend, m_irq, m_tout, m_en, m_tk, m_slowtk;

  always #4 clk = ~clk;

  itv_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .csel_i(csel), .pre_en_i(pre_en), .slow_en_i(slow_en),
    .period_i(period), .period_we_i(we), .irq_at_start_i(mode),
    .irq_o(irq), .tout_o(tout), .count_o(count));

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    pre_en  <= {ncyc % 5 == 0, ncyc % 3 == 0, ncyc % 2 == 0, 1'b1};
    slow_en <= (ncyc % 2 == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_sel = 0; m_div = 0;
      m_run = 0; m_pend = 0; m_irq = 0; m_tout = 0;
    end else begin
      m_slowtk = (slow_en && m_div == 3);
      if (slow_en) m_div = (m_div + 1) % 4;
      if (m_sel < 4) m_en = pre_en[m_sel];
      else if (m_sel == 4) m_en = m_slowtk;
      else m_en = 0;
      m_tk = m_run && m_en;
      m_irq = 0;
      if (m_tk) begin
        if (m_pend) begin
          m_cnt = m_prd;
          if (mode) begin m_irq = 1; m_tout = !m_tout; end
        end else if (m_cnt == 0) begin
          m_cnt = m_prd; m_irq = 1; m_tout = !m_tout;
        end else m_cnt = m_cnt - 1;
      end
      if (!m_run) m_sel = csel;
      if (we) m_prd = period;
      if (stop) begin m_run = 0; m_pend = 0; end
      else if (start) begin m_run = 1; m_pend = 1; end
      else if (m_tk) m_pend = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(count == 16'(m_cnt), "R2 count", count, m_cnt);
    check(irq == m_irq[0], "R4 irq", irq, m_irq);
    check(tout == m_tout[0], "R5 tout", tout, m_tout);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic write_period(input int v);
    period = 16'(v); we = 1'b1; @(negedge clk); we = 1'b0;
  endtask
  task automatic wait_irq();
    do @(negedge clk); while (irq !== 1'b1);
  endtask
  task automatic gap(input int start_n, output int n);
    n = start_n;
    do begin @(negedge clk); n++; end while (irq !== 1'b1);
  endtask

  initial begin
    int g;
    logic [15:0] hc;
    logic ht, t0;
    repeat (3) @(negedge clk);
    check(irq == 0 && tout == 0 && count == 0, "R1 reset", {irq, tout, count}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    csel = 3'd0; mode = 1'b0;
    write_period(3);
    pulse_start();
    @(negedge clk);
    check(count == 3, "R3 load value", count, 3);
    check(irq == 0, "R3 no irq mode0", irq, 0);
    check(tout == 0, "R3 no toggle mode0", tout, 0);
    wait_irq();
    t0 = tout;
    gap(0, g);
    check(g == 4, "R6 interval P=3", g, 4);
    check(tout != t0, "R5 toggle per irq", tout, !t0);

    csel = 3'd3;
    gap(0, g);
    check(g == 4, "R9 select frozen while running", g, 4);
    csel = 3'd0;

    pulse_stop();
    @(negedge clk);
    hc = count; ht = tout;
    repeat (10) @(negedge clk);
    check(count == hc, "R8 count held", count, hc);
    check(tout == ht, "R8 tout held", tout, ht);

    stop = 1'b1; start = 1'b1; @(negedge clk); stop = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);
    check(count == hc, "R8 stop wins over start", count, hc);

    mode = 1'b1;
    write_period(9);
    t0 = tout;
    pulse_start();
    @(negedge clk);
    check(irq == 1, "R3 irq on start mode1", irq, 1);
    check(tout != t0, "R3 toggle on start mode1", tout, !t0);
    check(count == 9, "R3 load value mode1", count, 9);
    write_period(2);
    gap(1, g);
    check(g == 10, "R7 current period unchanged", g, 10);
    gap(0, g);
    check(g == 3, "R7 new period next", g, 3);

    pulse_stop();
    csel = 3'd4; mode = 1'b0;
    write_period(0);
    pulse_start();
    wait_irq();
    gap(0, g);
    check(g == 8, "R10 slow divided by 4", g, 8);

    pulse_stop();
    csel = 3'd1;
    write_period(1);
    pulse_start();
    wait_irq();
    gap(0, g);
    check(g == 4, "R9 select 1 half rate", g, 4);

    pulse_stop();
    csel = 3'd5;
    pulse_start();
    @(negedge clk);
    hc = count;
    repeat (20) @(negedge clk);
    check(count == hc && irq == 0, "R9 select 5 no ticks", count, hc);
    pulse_stop();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule